// File: doc/BRIEF.md
# Event-Counting Performance Monitor

This block counts clock cycles and selected hardware events for a processor core. It has one cycle counter and a set of programmable 32-bit event counters (four by default). Each event counter takes an 8-bit code that picks one line out of a vector of single-cycle event pulses. When any counter wraps past its maximum value, it sets a sticky overflow flag. If that flag's enable bit is also set, the block raises a level interrupt.

Software reaches the block through a simple synchronous register port. Read data appears one cycle after the read strobe. To take periodic samples, software preloads a counter to a value short of the wrap point, waits for the interrupt, and clears the flag by writing 1 to it. A prescale mode makes the cycle counter advance only once every 64 clocks, which extends its range.

Top module: `evt_perf_mon`

Register word addresses:

| Address | Register |
|---|---|
| 0x00 | control |
| 0x04 | cycle counter |
| 0x08 | interrupt enable |
| 0x0C | overflow flags |
| 0x10 | event select |
| 0x14, 0x18, 0x1C, 0x20 | event counters 0, 1, 2 and 3 |

## Requirements
- R1: After reset, every counter reads 0, the overflow flags and interrupt enables read 0, event select reads 0xFFFFFFFF, control reads 0xA5000000 and irq_o is low.
- R2: While control bit 0 (enable) is clear, no counter advances, whatever the event inputs do.
- R3: Event counter k counts each clock in which enable is set and event_i[c] is high. Here c is the code in event-select bits 8k+7:8k, and code value N selects input bit N.
- R4: Event code 0xFF, or any code of NUM_SRC (24) or above, keeps its counter at its current value.
- R5: With enable set and control bit 3 clear, the cycle counter advances by one each clock.
- R6: With control bits 0 and 3 both set, the cycle counter advances once per 64 enabled clocks. Clearing enable restarts that 64-clock count.
- R7: Writing control with bit 1 set zeroes all event counters. Writing it with bit 2 set zeroes the cycle counter. Neither bit is stored.
- R8: A control read returns enable in bit 0, prescale in bit 3 and the fixed code 0xA5 in bits 31:24. All other bits read 0.
- R9: Writing a counter's address preloads that counter. A counter that advances from 0xFFFFFFFF goes to 0 and sets its overflow flag: bit 0 for the cycle counter, bit k+1 for event counter k.
- R10: Writing 1 to an overflow-flag bit clears it. Writing 0 leaves it unchanged.
- R11: The interrupt-enable bits sit at the same positions as the flags. irq_o is high exactly when some flag and its matching enable are both set.
- R12: If a counter wraps in the same clock as a write-1-to-clear of its flag, the flag ends up set.
- R13: reg_rdata_o shows the register value from the clock edge at which reg_rd_i was sampled, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 6 | Byte address, word aligned |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered |
| event_i | input | 24 | Event pulse lines, one per event code |
| irq_o | output | 1 | Overflow interrupt, level |

## Verification
A fault in a counter's increment gating shows up as a wrong count at the very next read of that counter. A stuck enable or a broken prescaler gives an error that grows by one per clock, or by one per 64 clocks, for as long as the counter runs. A faulty overflow flag shows at irq_o within one cycle of writing the interrupt-enable register. A faulty wrap-versus-clear priority shows only when the wrap and the flag write land on the same edge, so the bench lines them up deliberately.

// File: rtl/evt_pmu_pkg.sv
package evt_pmu_pkg;
  localparam int DATA_W = 32;

  // control bit positions
  localparam int CTRL_EN    = 0;
  localparam int CTRL_EVCLR = 1;
  localparam int CTRL_CYCLR = 2;
  localparam int CTRL_DIV   = 3;

  // word indices (byte address >> 2)
  localparam int IDX_CTRL  = 0;
  localparam int IDX_CYC   = 1;
  localparam int IDX_IEN   = 2;
  localparam int IDX_FLAG  = 3;
  localparam int IDX_EVSEL = 4;
  localparam int IDX_EV0   = 5;

  typedef logic [7:0] evt_code_t;
  localparam evt_code_t CODE_OFF = 8'hFF;
endpackage

// File: rtl/pmu_event_mux.sv
module pmu_event_mux #(
  parameter int NUM_SRC = 24,
  parameter int CODE_W  = 8
) (
  input  logic [CODE_W-1:0]  code_i,
  input  logic [NUM_SRC-1:0] event_i,
  output logic               hit_o
);
  // unmatched codes (incl. all-ones) select nothing
  always_comb begin
    hit_o = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (code_i == CODE_W'(s)) hit_o = event_i[s];
    end
  end
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] value_o,
  output logic         wrap_o
);
  logic [W-1:0] q;

  // software load > zero strobe > count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= load_val_i;
    else if (clr_i)  q <= '0;
    else if (inc_i)  q <= q + 1'b1;
  end

  assign value_o = q;
  assign wrap_o  = inc_i && !load_i && !clr_i && (&q);
endmodule

// File: rtl/evt_perf_mon.sv
module evt_perf_mon
  import evt_pmu_pkg::*;
#(
  parameter int        NUM_EVT  = 4,
  parameter int        CNT_W    = 32,
  parameter int        CODE_W   = 8,
  parameter int        NUM_SRC  = 24,
  parameter int        PRESCALE = 64,
  parameter int        ADDR_W   = 6,
  parameter logic [7:0] ID_CODE = 8'hA5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [NUM_SRC-1:0] event_i,
  output logic               irq_o
);
  localparam int NUM_CNT = NUM_EVT + 1;
  localparam int EVSEL_W = NUM_EVT * CODE_W;
  localparam int IDX_W   = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             aligned;
  logic             wr_ctrl, wr_ien, wr_flag, wr_evsel;

  logic                        en_q, div_q;
  logic [NUM_CNT-1:0]          ien_q, flag_q;
  logic [EVSEL_W-1:0]          evsel_q;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;
  logic [NUM_CNT-1:0]          cnt_load, cnt_clr, cnt_inc, wrap_vec;
  logic [NUM_EVT-1:0]          ev_hit;
  logic                        div_tick;
  logic [DATA_W-1:0]           rd_mux, rdata_q;

  assign word_idx = reg_addr_i[ADDR_W-1:2];
  assign aligned  = (reg_addr_i[1:0] == 2'b00);
  assign wr_ctrl  = reg_wr_i && aligned && (word_idx == IDX_W'(IDX_CTRL));
  assign wr_ien   = reg_wr_i && aligned && (word_idx == IDX_W'(IDX_IEN));
  assign wr_flag  = reg_wr_i && aligned && (word_idx == IDX_W'(IDX_FLAG));
  assign wr_evsel = reg_wr_i && aligned && (word_idx == IDX_W'(IDX_EVSEL));

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      div_q   <= 1'b0;
      ien_q   <= '0;
      evsel_q <= '1;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata_i[CTRL_EN];
        div_q <= reg_wdata_i[CTRL_DIV];
      end
      if (wr_ien)   ien_q   <= reg_wdata_i[NUM_CNT-1:0];
      if (wr_evsel) evsel_q <= reg_wdata_i[EVSEL_W-1:0];
    end
  end

  // sticky flags: a new wrap beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~(wr_flag ? reg_wdata_i[NUM_CNT-1:0] : '0)) | wrap_vec;
  end

  pmu_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_q && div_q),
    .tick_o (div_tick)
  );

  // cycle counter controls
  assign cnt_load[0] = reg_wr_i && aligned && (word_idx == IDX_W'(IDX_CYC));
  assign cnt_clr[0]  = wr_ctrl && reg_wdata_i[CTRL_CYCLR];
  assign cnt_inc[0]  = en_q && (div_q ? div_tick : 1'b1);

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    pmu_event_mux #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_mux (
      .code_i  (evsel_q[k*CODE_W +: CODE_W]),
      .event_i (event_i),
      .hit_o   (ev_hit[k])
    );
    assign cnt_load[k+1] = reg_wr_i && aligned && (word_idx == IDX_W'(IDX_EV0 + k));
    assign cnt_clr[k+1]  = wr_ctrl && reg_wdata_i[CTRL_EVCLR];
    assign cnt_inc[k+1]  = en_q && ev_hit[k];
  end

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (cnt_load[c]),
      .load_val_i (reg_wdata_i[CNT_W-1:0]),
      .clr_i      (cnt_clr[c]),
      .inc_i      (cnt_inc[c]),
      .value_o    (cnt_val[c]),
      .wrap_o     (wrap_vec[c])
    );
  end

  // read path
  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (int'(word_idx))
        IDX_CTRL: begin
          rd_mux[31:24]    = ID_CODE;
          rd_mux[CTRL_DIV] = div_q;
          rd_mux[CTRL_EN]  = en_q;
        end
        IDX_CYC:   rd_mux = DATA_W'(cnt_val[0]);
        IDX_IEN:   rd_mux = DATA_W'(ien_q);
        IDX_FLAG:  rd_mux = DATA_W'(flag_q);
        IDX_EVSEL: rd_mux = DATA_W'(evsel_q);
        default: begin
          for (int k = 0; k < NUM_EVT; k++) begin
            if (int'(word_idx) == IDX_EV0 + k) rd_mux = DATA_W'(cnt_val[k+1]);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = |(flag_q & ien_q);
endmodule

// File: rtl/evt_perf_mon_chk.sv
module evt_perf_mon_chk #(
  parameter int NUM_CNT = 5,
  parameter int CNT_W   = 32,
  parameter int CODE_W  = 8,
  parameter int ADDR_W  = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_wr_i,
  input logic               reg_rd_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [31:0]        reg_rdata_o,
  input logic               irq_o,
  input logic               en_q,
  input logic               div_q,
  input logic [NUM_CNT-1:0] ien_q,
  input logic [NUM_CNT-1:0] flag_q,
  input logic [NUM_CNT-1:0] wrap_vec,
  input logic [CODE_W-1:0]  ev0_code,
  input logic [CNT_W-1:0]   cyc_val,
  input logic               cyc_load,
  input logic               cyc_clr,
  input logic [CNT_W-1:0]   ev0_val,
  input logic               ev0_load,
  input logic               ev0_clr
);
  logic flag_wr, ctrl_rd;
  assign flag_wr = reg_wr_i && (reg_addr_i == ADDR_W'(12));
  assign ctrl_rd = reg_rd_i && (reg_addr_i == ADDR_W'(0));

  // R2
  halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !cyc_load && !cyc_clr) |=> (cyc_val == $past(cyc_val)));

  // R4
  unused_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev0_code == {CODE_W{1'b1}} && !ev0_load && !ev0_clr) |=> (ev0_val == $past(ev0_val)));

  // R5
  cyc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !div_q && !cyc_load && !cyc_clr) |=> (cyc_val == $past(cyc_val) + 1'b1));

  // R8
  ctrl_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rd |=> ((reg_rdata_o & 32'h00FF_FFF6) == 32'h0));

  // R9
  wrap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wrap_vec) |=> ((flag_q & $past(wrap_vec)) == $past(wrap_vec)));

  // R10
  flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R11
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((|ien_q) && (|flag_q)));
endmodule

bind evt_perf_mon evt_perf_mon_chk #(
  .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .en_q        (en_q),
  .div_q       (div_q),
  .ien_q       (ien_q),
  .flag_q      (flag_q),
  .wrap_vec    (wrap_vec),
  .ev0_code    (evsel_q[CODE_W-1:0]),
  .cyc_val     (cnt_val[0]),
  .cyc_load    (cnt_load[0]),
  .cyc_clr     (cnt_clr[0]),
  .ev0_val     (cnt_val[1]),
  .ev0_load    (cnt_load[1]),
  .ev0_clr     (cnt_clr[1])
);

// File: tb/evt_perf_mon_test.sv
module evt_perf_mon_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [23:0] event_i = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evt_perf_mon uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .event_i     (event_i),
    .irq_o       (irq_o)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IDLE = 2'd2;
  localparam int NV = 23;
  // {op, requirement number, address, data or expected value}
  localparam logic [43:0] VEC [NV] = '{
    {OP_RD,   4'd1,  6'h00, 32'hA500_0000}, // R1
    {OP_RD,   4'd1,  6'h10, 32'hFFFF_FFFF}, // R1
    {OP_RD,   4'd1,  6'h0C, 32'h0},         // R1
    {OP_RD,   4'd1,  6'h04, 32'h0},         // R1
    {OP_RD,   4'd1,  6'h20, 32'h0},         // R1
    {OP_WR,   4'd8,  6'h00, 32'hFFFF_FFF8},
    {OP_RD,   4'd8,  6'h00, 32'hA500_0008}, // R8
    {OP_WR,   4'd9,  6'h04, 32'h1234_5678},
    {OP_RD,   4'd9,  6'h04, 32'h1234_5678}, // R9 preload
    {OP_WR,   4'd7,  6'h00, 32'h0000_0004},
    {OP_RD,   4'd7,  6'h04, 32'h0},         // R7 cycle zero
    {OP_RD,   4'd8,  6'h00, 32'hA500_0000}, // R8 strobe not stored
    {OP_WR,   4'd11, 6'h08, 32'hFFFF_FFFF},
    {OP_RD,   4'd11, 6'h08, 32'h0000_001F}, // R11
    {OP_WR,   4'd3,  6'h10, 32'h0A0B_0C0D},
    {OP_RD,   4'd3,  6'h10, 32'h0A0B_0C0D}, // R3
    {OP_WR,   4'd7,  6'h1C, 32'h0000_DEAD},
    {OP_RD,   4'd7,  6'h1C, 32'h0000_DEAD},
    {OP_WR,   4'd7,  6'h00, 32'h0000_0002},
    {OP_RD,   4'd7,  6'h1C, 32'h0},         // R7 event zero
    {OP_IDLE, 4'd2,  6'h00, 32'd5},
    {OP_RD,   4'd2,  6'h04, 32'h0},         // R2
    {OP_WR,   4'd11, 6'h08, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    reg_rd_i = 1'b1; reg_addr_i = a;
    @(negedge clk);
    reg_rd_i = 1'b0;
    chk(tag, reg_rdata_o, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    chk("R1", {31'b0, irq_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][43:42])
        OP_WR:   wr(VEC[i][37:32], VEC[i][31:0]);
        OP_RD:   rd_chk($sformatf("R%0d table %0d", VEC[i][41:38], i), VEC[i][37:32], VEC[i][31:0]);
        default: idle(int'(VEC[i][31:0]));
      endcase
    end

    // R5: 10 idle + enable edge + disable edge -> 11 counts
    wr(6'h04, 0); wr(6'h00, 1); idle(10); wr(6'h00, 0);
    rd_chk("R5", 6'h04, 32'd11);

    // R6: 63 enabled clocks -> 0, then 64 -> 1, then 200 -> 3
    wr(6'h04, 0); wr(6'h00, 9); idle(62); wr(6'h00, 0);
    rd_chk("R6 63 clocks", 6'h04, 32'd0);
    wr(6'h00, 9); idle(63); wr(6'h00, 0);
    rd_chk("R6 64 clocks", 6'h04, 32'd1);
    wr(6'h04, 0); wr(6'h00, 9); idle(199); wr(6'h00, 0);
    rd_chk("R6 200 clocks", 6'h04, 32'd3);

    // R3/R4/R2: codes c0=0x05, c1=0x07, c2=0x18 (no input), c3=0xFF
    wr(6'h10, 32'hFF18_0705); wr(6'h00, 2);
    event_i = '1; idle(3); event_i = '0;
    rd_chk("R2 events while disabled", 6'h14, 32'd0);
    wr(6'h00, 1);
    for (int i = 0; i < 8; i++) begin
      event_i = '1;
      event_i[5] = (i % 2 == 0);
      @(negedge clk);
    end
    event_i = '0;
    wr(6'h00, 0);
    rd_chk("R3 counter0 code 05", 6'h14, 32'd4);
    rd_chk("R3 counter1 code 07", 6'h18, 32'd8);
    rd_chk("R4 counter2 code 18", 6'h1C, 32'd0);
    rd_chk("R4 counter3 code FF", 6'h20, 32'd0);

    // R9/R10/R11: event counter 0 wraps
    wr(6'h08, 0); wr(6'h0C, 32'h1F);
    wr(6'h10, 32'hFFFF_FF05); wr(6'h14, 32'hFFFF_FFFE);
    wr(6'h00, 1);
    event_i[5] = 1'b1; idle(2); event_i = '0;
    wr(6'h00, 0);
    rd_chk("R9 wrap to zero", 6'h14, 32'd0);
    rd_chk("R9 flag bit1", 6'h0C, 32'h2);
    chk("R11 flag without enable", {31'b0, irq_o}, 32'h0);
    wr(6'h08, 32'h2);
    chk("R11 flag with enable", {31'b0, irq_o}, 32'h1);
    wr(6'h08, 32'h1D);
    chk("R11 other enables only", {31'b0, irq_o}, 32'h0);
    wr(6'h08, 32'h2);
    wr(6'h0C, 32'h1D);
    rd_chk("R10 write zero keeps flag", 6'h0C, 32'h2);
    chk("R10 irq still high", {31'b0, irq_o}, 32'h1);
    wr(6'h0C, 32'h2);
    rd_chk("R10 write one clears", 6'h0C, 32'h0);
    chk("R11 irq drops", {31'b0, irq_o}, 32'h0);

    // R9: cycle counter wrap sets bit 0
    wr(6'h04, 32'hFFFF_FFFF); wr(6'h00, 1); wr(6'h00, 0);
    rd_chk("R9 cycle flag bit0", 6'h0C, 32'h1);
    rd_chk("R9 cycle wrap to zero", 6'h04, 32'd0);
    wr(6'h0C, 32'h1);

    // R12: wrap on the same edge as the clear
    wr(6'h08, 0); wr(6'h14, 32'hFFFF_FFFF); wr(6'h00, 1);
    event_i[5] = 1'b1;
    wr(6'h0C, 32'h2);
    event_i = '0;
    wr(6'h00, 0);
    rd_chk("R12 flag survives clear", 6'h0C, 32'h2);

    // R13: read returns value at the strobe edge
    wr(6'h04, 0); wr(6'h00, 1);
    rd_chk("R13 first read", 6'h04, 32'd0);
    rd_chk("R13 second read", 6'h04, 32'd1);
    wr(6'h00, 0);
    idle(2);
    chk("R13 data held", reg_rdata_o, 32'd1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule